// File: doc/BRIEF.md
# Exp-Golomb Syntax Element Decoder

This block turns one exponential-Golomb codeword at the head of a bitstream window into a syntax element value. A separate detector has already found how many zero bits precede the first one bit. That count arrives on its own input and gives the prefix length. The decoder takes the information field of the same length that follows the one bit, forms the code number, and maps it to a value in one of three ways: unsigned, signed or truncated. It also returns the number of bits the codeword occupied, so that the bitstream buffer feeding the window can advance by that amount.

A request is a single-cycle strobe. Value, consumed length and a valid flag appear together on registered outputs in the next cycle. Between requests the outputs hold their last result.

Top module: `expg_elem_decoder`

## Requirements
- R1: The window is read MSB first: bit 31 is the oldest bit. A codeword is `lead_pos` zero bits, then a one bit, then an information field of `lead_pos` bits. `lead_pos` ranges from 0 to 15 and is trusted as given.
- R2: The code number is 2^lead_pos - 1 plus the information field read as an unsigned number. In mode 0 (unsigned) the value output is this code number. Bits of the window after the codeword have no effect on any output.
- R3: The consumed length is 2*lead_pos+1 in every case except the one in R6.
- R4: In mode 1 (signed), an odd code number k gives +(k+1)/2 and an even code number k gives -k/2. The result is a 16-bit two's-complement value.
- R5: In mode 2 (truncated), a range input other than 1, including 0, decodes exactly as mode 0.
- R6: In mode 2 with a range of exactly 1, the value is the inverse of window bit 31, zero-extended, and the consumed length is 1. `lead_pos` is ignored.
- R7: Mode 3 decodes exactly as mode 0.
- R8: `valid` is high in exactly the cycle after a cycle with `start` high. Value and length for that request are presented in that same cycle.
- R9: While `start` is low, `value` and `used_len` keep their last values and `valid` stays low.
- R10: A synchronous active-low reset clears `valid`, `value` and `used_len` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Decode request strobe |
| window | input | 32 | Bitstream window, oldest bit in bit 31 |
| lead_pos | input | 4 | Number of leading zeros before the first one |
| mode | input | 2 | 0 unsigned, 1 signed, 2 truncated, 3 treated as unsigned |
| trunc_range | input | 16 | Upper bound for truncated mode |
| value | output | 16 | Decoded syntax element value |
| used_len | output | 5 | Bits consumed by the codeword |
| valid | output | 1 | Result strobe, one cycle after start |

## Verification
The bench decodes every codeword with a prefix of up to nine zeros, in all four modes. For the longer prefixes up to fifteen zeros it uses the all-zero and all-one information fields plus sampled ones, and it fills the bits after each codeword with noise. These cases catch an off-by-one in the suffix shift: such a design would take a tail bit into the code number, or drop the last suffix bit, at the longest codewords. The signed sweep exposes a swapped sign convention or a missing round-up on odd codes. The single-bit truncated case catches a design that keeps reporting 2M+1 bits, or that forgets to invert the bit, when the range is 1. Range 0 shows whether that special case is over-matched. The hold check after each burst shows whether outputs change without a request.

// File: rtl/expg_pkg.sv
// Shared definitions for the Exp-Golomb element decoder.
package expg_pkg;
    // Value mapping selected per request.
    typedef enum logic [1:0] {
        MAP_UNS = 2'd0,
        MAP_SGN = 2'd1,
        MAP_TRN = 2'd2,
        MAP_RSV = 2'd3
    } map_mode_e;
endpackage

// File: rtl/expg_codenum.sv
// Code number extraction.
// Takes the zero-prefix length from an external detector and pulls the
// information field that follows the one bit. It forms the code number and
// the codeword length 2M+1.
// Assumes: window MSB is the oldest bit, WIN_W >= 2*MAX_M+1, and the
// prefix count is correct. The one bit itself is not checked.
module expg_codenum #(
    parameter int WIN_W = 32,
    parameter int POS_W = 4,
    localparam int MAX_M = (1 << POS_W) - 1,
    localparam int CN_W  = MAX_M + 1,
    localparam int LEN_W = POS_W + 1
) (
    input  logic [WIN_W-1:0] bits_in,
    input  logic [POS_W-1:0] zeros,
    output logic [CN_W-1:0]  code_num,
    output logic [LEN_W-1:0] cw_len
);
    logic [POS_W:0]   skip;
    logic [WIN_W-1:0] shifted;
    logic [MAX_M-1:0] info_top;
    logic [MAX_M-1:0] info;
    logic [CN_W-1:0]  base;

    // Align the information field to the top, then right-justify it to M bits.
    always_comb begin
        skip     = {1'b0, zeros} + {{POS_W{1'b0}}, 1'b1};
        shifted  = bits_in << skip;
        info_top = shifted[WIN_W-1 -: MAX_M];
        info     = info_top >> (MAX_M - int'(zeros));
        base     = (CN_W'(1) << zeros) - CN_W'(1);
        code_num = base + {1'b0, info};
        cw_len   = {zeros, 1'b1};
    end
endmodule

// File: rtl/expg_map.sv
// Value mapping.
// Turns a code number into an unsigned, signed or truncated element value and
// picks the consumed length. The one-bit truncated form (range == 1) bypasses
// the code number and uses the first window bit directly.
// Assumes: VAL_W equals the code number width, so signed results fit.
module expg_map
    import expg_pkg::*;
#(
    parameter int CN_W    = 16,
    parameter int RANGE_W = 16,
    parameter int LEN_W   = 5,
    localparam int VAL_W  = CN_W
) (
    input  logic [CN_W-1:0]    code_num,
    input  logic [LEN_W-1:0]   cw_len,
    input  map_mode_e          mode,
    input  logic [RANGE_W-1:0] range_max,
    input  logic               first_bit,
    output logic [VAL_W-1:0]   val,
    output logic [LEN_W-1:0]   len,
    output logic               short_cw
);
    logic [VAL_W-1:0] half;

    // Select the mapping for the requested mode.
    always_comb begin
        half     = {1'b0, code_num[CN_W-1:1]};
        short_cw = (mode == MAP_TRN) && (range_max == RANGE_W'(1));
        len      = cw_len;
        unique case (mode)
            MAP_SGN: val = code_num[0] ? (half + VAL_W'(1)) : (VAL_W'(0) - half);
            default: val = code_num;
        endcase
        if (short_cw) begin
            val = {{(VAL_W-1){1'b0}}, ~first_bit};
            len = LEN_W'(1);
        end
    end
endmodule

// File: rtl/expg_elem_decoder.sv
// Exp-Golomb syntax element decoder, top level.
// One request per start strobe. The value, the consumed length and valid are
// registered and appear on the cycle after start. Outputs hold between
// requests. Assumes lead_pos comes from a correct leading-one detector.
module expg_elem_decoder
    import expg_pkg::*;
#(
    parameter int WIN_W   = 32,
    parameter int POS_W   = 4,
    parameter int RANGE_W = 16,
    localparam int MAX_M  = (1 << POS_W) - 1,
    localparam int CN_W   = MAX_M + 1,
    localparam int VAL_W  = CN_W,
    localparam int LEN_W  = POS_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIN_W-1:0]   window,
    input  logic [POS_W-1:0]   lead_pos,
    input  logic [1:0]         mode,
    input  logic [RANGE_W-1:0] trunc_range,
    output logic [VAL_W-1:0]   value,
    output logic [LEN_W-1:0]   used_len,
    output logic               valid
);
    logic [CN_W-1:0]  code_num;
    logic [LEN_W-1:0] cw_len;
    logic [VAL_W-1:0] map_val;
    logic [LEN_W-1:0] map_len;
    logic             short_cw;

    expg_codenum #(.WIN_W(WIN_W), .POS_W(POS_W)) u_cn (
        .bits_in (window),
        .zeros   (lead_pos),
        .code_num(code_num),
        .cw_len  (cw_len)
    );

    expg_map #(.CN_W(CN_W), .RANGE_W(RANGE_W), .LEN_W(LEN_W)) u_map (
        .code_num (code_num),
        .cw_len   (cw_len),
        .mode     (map_mode_e'(mode)),
        .range_max(trunc_range),
        .first_bit(window[WIN_W-1]),
        .val      (map_val),
        .len      (map_len),
        .short_cw (short_cw)
    );

    // Register the result on a request; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid    <= 1'b0;
            value    <= '0;
            used_len <= '0;
        end else begin
            valid <= start;
            if (start) begin
                value    <= map_val;
                used_len <= map_len;
            end
        end
    end

    // Bounds on the code number for the given prefix length, for checking.
    logic [CN_W:0] lo_bound, hi_bound;
    always_comb begin
        lo_bound = ((CN_W+1)'(1) << lead_pos) - (CN_W+1)'(1);
        hi_bound = ((CN_W+1)'(2) << lead_pos) - (CN_W+1)'(2);
    end

    // R8: a result strobe follows every request.
    a_r8_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    // R9: no strobe without a request.
    a_r9_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    // R9: outputs hold while idle.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(value) && $stable(used_len)));
    // R3: every reported length is odd.
    a_r3_len_odd: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> used_len[0]);
    // R2: code number lies in the band its prefix length allows.
    a_r2_code_band: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !short_cw) |-> ({1'b0, code_num} >= lo_bound && {1'b0, code_num} <= hi_bound));
    // R4: sign of a signed result follows the code number parity.
    a_r4_sign_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 2'd1 && code_num != '0) |-> (map_val[VAL_W-1] == ~code_num[0]));
    // R6: the one-bit truncated form consumes one bit.
    a_r6_short_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && short_cw) |=> (used_len == LEN_W'(1)));
endmodule

// File: tb/expg_elem_decoder_test.sv
module expg_elem_decoder_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] window;
    logic [3:0]  lead_pos;
    logic [1:0]  mode;
    logic [15:0] trunc_range;
    logic [15:0] value;
    logic [4:0]  used_len;
    logic        valid;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    expg_elem_decoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .window(window),
        .lead_pos(lead_pos), .mode(mode), .trunc_range(trunc_range),
        .value(value), .used_len(used_len), .valid(valid)
    );

    task automatic check(input string req, input logic [15:0] ev, input logic [4:0] el,
                         input logic evld);
        n_chk++;
        if (value !== ev || used_len !== el || valid !== evld) begin
            n_bad++;
            $display("FAIL %s: value=%h len=%0d valid=%b expected value=%h len=%0d valid=%b",
                     req, value, used_len, valid, ev, el, evld);
        end
    endtask

    // Build a window holding the codeword, with noise after it; decode; check.
    task automatic decode(input int m, input int suf, input logic [1:0] md,
                          input logic [15:0] rng, input string req);
        int          L;
        int          k;
        int          sv;
        logic [31:0] w;
        logic [15:0] ev;
        logic [4:0]  el;
        L = 2*m + 1;
        w = $urandom;
        w = w & ((32'h1 << (32 - L)) - 32'h1);
        w = w | (((32'h1 << m) | 32'(suf)) << (32 - L));
        k = (1 << m) - 1 + suf;
        if (md == 2'd1) sv = (k % 2 == 1) ? (k + 1) / 2 : -(k / 2);
        else            sv = k;
        ev = sv[15:0];
        el = 5'(L);
        window = w; lead_pos = 4'(m); mode = md; trunc_range = rng; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(req, ev, el, 1'b1);
    endtask

    // One-bit truncated form: value is the inverted first bit, length 1.
    task automatic decode_short(input logic msb, input int m);
        logic [31:0] w;
        w = $urandom;
        w[31] = msb;
        window = w; lead_pos = 4'(m); mode = 2'd2; trunc_range = 16'd1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R6 short truncated", {15'd0, ~msb}, 5'd1, 1'b1);
    endtask

    // Idle cycle with changed inputs: outputs must hold, valid low.
    task automatic idle_hold;
        logic [15:0] pv;
        logic [4:0]  pl;
        pv = value; pl = used_len;
        window = $urandom; lead_pos = 4'($urandom); mode = 2'($urandom);
        @(posedge clk);
        @(negedge clk);
        check("R9 hold while idle", pv, pl, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not end, actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; window = '0; lead_pos = '0; mode = '0; trunc_range = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset state", 16'd0, 5'd0, 1'b0);
        // Request during reset must not leave a result (R10).
        start = 1'b1; window = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R10 reset overrides start", 16'd0, 5'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 unsigned, R4 signed, R5 truncated range 5, R7 mode 3: exhaustive to M=9.
        for (int md = 0; md < 4; md++) begin
            for (int m = 0; m < 10; m++)
                for (int s = 0; s < (1 << m); s++)
                    decode(m, s, 2'(md), 16'd5, "R1/R2/R3/R4/R5/R7 sweep");
            idle_hold();
        end

        // Long codewords, M 10..15: extreme and sampled suffixes (R1, R2, R3, R4).
        for (int md = 0; md < 3; md++)
            for (int m = 10; m < 16; m++) begin
                decode(m, 0, 2'(md), 16'd9, "R2 long min suffix");
                decode(m, (1 << m) - 1, 2'(md), 16'd9, "R3 long max suffix");
                for (int j = 0; j < 20; j++)
                    decode(m, int'($urandom) & ((1 << m) - 1), 2'(md), 16'd9, "R4 long sampled");
            end
        idle_hold();

        // R5: range 0 and range 2 follow the ordinary decode.
        for (int m = 0; m < 6; m++) begin
            decode(m, 0, 2'd2, 16'd0, "R5 truncated range 0");
            decode(m, (1 << m) - 1, 2'd2, 16'd2, "R5 truncated range 2");
        end

        // R6: range 1, both first-bit values, M ignored.
        for (int m = 0; m < 16; m += 3) begin
            decode_short(1'b0, m);
            decode_short(1'b1, m);
        end
        idle_hold();

        // R8: back-to-back requests each produce their own result.
        decode(3, 5, 2'd1, 16'd0, "R8 back-to-back a");
        decode(0, 0, 2'd0, 16'd0, "R8 back-to-back b");
        idle_hold();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule